// File: doc/BRIEF.md
# Interleaved-Tile Outer-Product Accumulator

This block keeps a matrix accumulator of 64 rows, each holding sixteen 32-bit lanes. The rows are split into four interleaved tiles, and tile `t` owns every fourth row starting at row `t`. A command carries a 64-bit operand, a subtract flag and two 16-lane input vectors, X and Y. The block forms the outer product of X and Y and applies it to the selected tile in one of three ways: it adds it, subtracts it, or writes it over the old contents.

The block captures the command and both vectors on the cycle it accepts the command. It then updates one accumulator row per cycle for sixteen cycles, and holds `busy` for that whole time. Lanes are signed 32-bit integers, and all arithmetic wraps modulo 2^32. A read port returns any accumulator row by index. The read is combinational and shows every row update that has completed.

Top module: `tile_outer_acc`

## Requirements
- R1: While reset is asserted, and after it is released, `busy` is 0, `cmd_ready` is 1 and every accumulator row reads as all zeros.
- R2: A command is accepted only on a rising edge where `cmd_valid` and `cmd_ready` are both 1. `cmd_ready` is low whenever `busy` is high. A command offered while busy changes no row and is not queued.
- R3: After an accept, `busy` is high for exactly 16 cycles. In each of those cycles exactly one accumulator row is written, in ascending index order.
- R4: Operand bits 21:20 select the tile `t`. The command writes only rows whose index modulo 4 equals `t`. Row `t+4j` is combined with Y lane `j`.
- R5: With `cmd_sub`=0 and operand bit 27 clear, each lane `i` of row `t+4j` gains X[i]·Y[j].
- R6: With `cmd_sub`=1 and operand bit 27 clear, each lane `i` of row `t+4j` loses X[i]·Y[j].
- R7: With operand bit 27 set, each lane `i` of row `t+4j` is replaced by X[i]·Y[j]. When `cmd_sub`=1 the value written is the negated product instead.
- R8: Operand bit 28 set treats every Y lane as zero. Operand bit 29 set treats every X lane as zero. All other operand bits have no effect.
- R9: `rd_row` returns row `rd_idx` in the same cycle. Lane `i` sits at bits 32i+31:32i, the same layout used by `x_vec` and `y_vec`. The value includes every row write completed before the read.
- R10: Products and sums keep only their low 32 bits, with no saturation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | A command is offered |
| cmd_ready | output | 1 | The block can accept a command |
| cmd_op | input | 64 | Command operand: tile select and flag bits |
| cmd_sub | input | 1 | Subtract variant of the command |
| x_vec | input | 512 | X vector, 16 lanes of 32 bits |
| y_vec | input | 512 | Y vector, 16 lanes of 32 bits |
| busy | output | 1 | A command is being applied |
| rd_idx | input | 6 | Index of the row to read |
| rd_row | output | 512 | Contents of the selected row |

## Verification
The assertions rely on two properties of the inputs. First, the operand, the subtract flag and both vectors only matter on the accept edge, so they may change freely at any other time. Second, `cmd_valid` needs no handshake discipline; the block may hold it off for as long as it likes. The stimulus changes every input on the falling clock edge. It keeps `cmd_valid` high through whole busy windows to exercise hold-off, and it drops the offer before `cmd_ready` returns, so that an offer made while busy is never taken once the block becomes ready.

// File: rtl/tile_acc_pkg.sv
package tile_acc_pkg;

    localparam int LANES     = 16;
    localparam int LANE_W    = 32;
    localparam int TILES     = 4;
    localparam int ROWS      = LANES * TILES;
    localparam int ROW_W     = LANES * LANE_W;
    localparam int IDX_W     = $clog2(ROWS);
    localparam int TILE_W    = $clog2(TILES);
    localparam int STEP_W    = $clog2(LANES);
    localparam int OP_W      = 64;

    // Operand field positions
    localparam int TILE_LSB  = 20;
    localparam int OVR_BIT   = 27;
    localparam int ZY_BIT    = 28;
    localparam int ZX_BIT    = 29;

    typedef logic [LANE_W-1:0] lane_t;
    typedef logic [ROW_W-1:0]  row_t;
    typedef logic [IDX_W-1:0]  idx_t;
    typedef logic [STEP_W-1:0] step_t;

    typedef struct packed {
        logic [TILE_W-1:0] tile;
        logic              zero_x;
        logic              zero_y;
        logic              overwrite;
        logic              negate;
    } cmd_t;

    // Combine one old lane value with one product, wrapping to 32 bits.
    function automatic lane_t combine_lane(lane_t old_v, lane_t prod,
                                           logic overwrite, logic negate);
        lane_t r;
        if (overwrite)
            r = negate ? (lane_t'(0) - prod) : prod;
        else
            r = negate ? (old_v - prod) : (old_v + prod);
        return r;
    endfunction

    // Row index written at step s of a command on tile t.
    function automatic idx_t row_of(step_t s, logic [TILE_W-1:0] t);
        return idx_t'(s) * idx_t'(TILES) + idx_t'(t);
    endfunction

endpackage

// File: rtl/acc_cmd_decode.sv
module acc_cmd_decode
    import tile_acc_pkg::*;
(
    input  logic [OP_W-1:0] op,
    input  logic            sub,
    output cmd_t            cmd
);
    logic unused_op_bits;

    always_comb begin
        cmd.tile      = op[TILE_LSB +: TILE_W];
        cmd.overwrite = op[OVR_BIT];
        cmd.zero_y    = op[ZY_BIT];
        cmd.zero_x    = op[ZX_BIT];
        cmd.negate    = sub;
    end

    assign unused_op_bits = ^{op[OP_W-1:ZX_BIT+1], op[OVR_BIT-1:TILE_LSB+TILE_W],
                              op[TILE_LSB-1:0]};
endmodule

// File: rtl/acc_sequencer.sv
module acc_sequencer
    import tile_acc_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [TILE_W-1:0] tile,
    output logic              busy,
    output step_t             step,
    output logic              wr_en,
    output idx_t              wr_idx
);
    always_ff @(posedge clk) begin
        if (rst) begin
            busy <= 1'b0;
            step <= '0;
        end else if (!busy) begin
            if (start) begin
                busy <= 1'b1;
                step <= '0;
            end
        end else if (step == step_t'(LANES - 1)) begin
            busy <= 1'b0;
            step <= '0;
        end else begin
            step <= step + step_t'(1);
        end
    end

    assign wr_en  = busy;
    assign wr_idx = row_of(step, tile);
endmodule

// File: rtl/acc_row_alu.sv
module acc_row_alu
    import tile_acc_pkg::*;
(
    input  row_t  x_row,
    input  lane_t y_lane,
    input  row_t  old_row,
    input  cmd_t  cmd,
    output row_t  new_row
);
    lane_t y_eff;
    assign y_eff = cmd.zero_y ? lane_t'(0) : y_lane;

    for (genvar i = 0; i < LANES; i++) begin : g_lane
        lane_t x_eff;
        lane_t prod;
        assign x_eff = cmd.zero_x ? lane_t'(0) : x_row[i*LANE_W +: LANE_W];
        assign prod  = x_eff * y_eff;
        assign new_row[i*LANE_W +: LANE_W] =
            combine_lane(old_row[i*LANE_W +: LANE_W], prod, cmd.overwrite, cmd.negate);
    end
endmodule

// File: rtl/acc_zbank.sv
module acc_zbank
    import tile_acc_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic we,
    input  idx_t widx,
    input  row_t wdata,
    input  idx_t ridx_a,
    output row_t rdata_a,
    input  idx_t ridx_b,
    output row_t rdata_b
);
    row_t mem [ROWS];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int r = 0; r < ROWS; r++) mem[r] <= '0;
        end else if (we) begin
            mem[widx] <= wdata;
        end
    end

    assign rdata_a = mem[ridx_a];
    assign rdata_b = mem[ridx_b];
endmodule

// File: rtl/tile_outer_acc.sv
module tile_outer_acc
    import tile_acc_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          cmd_valid,
    output logic          cmd_ready,
    input  logic [63:0]   cmd_op,
    input  logic          cmd_sub,
    input  logic [511:0]  x_vec,
    input  logic [511:0]  y_vec,
    output logic          busy,
    input  logic [5:0]    rd_idx,
    output logic [511:0]  rd_row
);
    cmd_t  cmd_in;
    cmd_t  cmd_q;
    row_t  x_q;
    row_t  y_q;
    logic  accept;
    step_t step;
    logic  wr_en;
    idx_t  wr_idx;
    row_t  old_row;
    row_t  new_row;
    lane_t y_lane;

    acc_cmd_decode u_dec (
        .op  (cmd_op),
        .sub (cmd_sub),
        .cmd (cmd_in)
    );

    assign cmd_ready = !busy;
    assign accept    = cmd_valid && cmd_ready;

    always_ff @(posedge clk) begin
        if (rst) begin
            cmd_q <= '0;
            x_q   <= '0;
            y_q   <= '0;
        end else if (accept) begin
            cmd_q <= cmd_in;
            x_q   <= x_vec;
            y_q   <= y_vec;
        end
    end

    acc_sequencer u_seq (
        .clk    (clk),
        .rst    (rst),
        .start  (accept),
        .tile   (cmd_q.tile),
        .busy   (busy),
        .step   (step),
        .wr_en  (wr_en),
        .wr_idx (wr_idx)
    );

    assign y_lane = y_q[step*LANE_W +: LANE_W];

    acc_row_alu u_alu (
        .x_row   (x_q),
        .y_lane  (y_lane),
        .old_row (old_row),
        .cmd     (cmd_q),
        .new_row (new_row)
    );

    acc_zbank u_bank (
        .clk     (clk),
        .rst     (rst),
        .we      (wr_en),
        .widx    (wr_idx),
        .wdata   (new_row),
        .ridx_a  (wr_idx),
        .rdata_a (old_row),
        .ridx_b  (rd_idx),
        .rdata_b (rd_row)
    );
endmodule

// File: rtl/tile_outer_acc_checker.sv
module tile_outer_acc_checker
    import tile_acc_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              cmd_valid,
    input logic              cmd_ready,
    input logic              busy,
    input logic              wr_en,
    input idx_t              wr_idx,
    input logic [TILE_W-1:0] tile_q
);
    logic [STEP_W:0] run_cnt;

    always_ff @(posedge clk) begin
        if (rst)       run_cnt <= '0;
        else if (busy) run_cnt <= run_cnt + 1'b1;
        else           run_cnt <= '0;
    end

    // R2
    busy_blocks_ready_chk: assert property (@(posedge clk) disable iff (rst)
        busy |-> !cmd_ready);

    // R2
    accept_starts_chk: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && cmd_ready) |=> busy);

    // R3
    busy_length_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> (run_cnt == (STEP_W+1)'(LANES)));

    // R3
    write_only_busy_chk: assert property (@(posedge clk) disable iff (rst)
        wr_en |-> busy);

    // R3
    row_stride_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && $past(wr_en)) |-> (wr_idx == $past(wr_idx) + idx_t'(TILES)));

    // R4
    tile_rows_chk: assert property (@(posedge clk) disable iff (rst)
        wr_en |-> (wr_idx[TILE_W-1:0] == tile_q));

    // R4
    tile_held_chk: assert property (@(posedge clk) disable iff (rst)
        (busy && $past(busy)) |-> $stable(tile_q));
endmodule

bind tile_outer_acc tile_outer_acc_checker u_chk (
    .clk       (clk),
    .rst       (rst),
    .cmd_valid (cmd_valid),
    .cmd_ready (cmd_ready),
    .busy      (busy),
    .wr_en     (wr_en),
    .wr_idx    (wr_idx),
    .tile_q    (cmd_q.tile)
);

// File: tb/tile_outer_acc_test.sv
`timescale 1ns/1ps
module tile_outer_acc_test;
    logic         clk = 1'b0;
    logic         rst;
    logic         cmd_valid;
    logic         cmd_ready;
    logic [63:0]  cmd_op;
    logic         cmd_sub;
    logic [511:0] x_vec;
    logic [511:0] y_vec;
    logic         busy;
    logic [5:0]   rd_idx;
    logic [511:0] rd_row;

    int vectors = 0;
    int errors  = 0;
    int cycles  = 0;

    logic [511:0] model [64];

    always #2.5 clk = ~clk;

    tile_outer_acc uut (
        .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
        .cmd_op(cmd_op), .cmd_sub(cmd_sub), .x_vec(x_vec), .y_vec(y_vec),
        .busy(busy), .rd_idx(rd_idx), .rd_row(rd_row)
    );

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            errors++;
            $display("FAIL watchdog: actual %0d cycles expected < 150000", cycles);
            $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
            $finish;
        end
    end

    task automatic check1(string tag, logic [511:0] act, logic [511:0] exp_v);
        vectors++;
        if (act !== exp_v) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp_v);
        end
    endtask

    task automatic check_all(string tag);
        for (int r = 0; r < 64; r++) begin
            rd_idx = 6'(r);
            #0.5;
            check1($sformatf("%s row %0d", tag, r), rd_row, model[r]);
        end
    endtask

    function automatic logic [511:0] make_vec(int seed);
        logic [511:0] v;
        for (int i = 0; i < 16; i++)
            v[i*32 +: 32] = 32'(seed) * 32'h9E3779B1 + 32'(i) * 32'h01000193 + 32'(i*i);
        return v;
    endfunction

    // Update the bench model from the requirements (R4..R8, R10).
    task automatic model_apply(logic [63:0] op, logic sub, logic [511:0] xv, logic [511:0] yv);
        int t = int'(op[21:20]);
        for (int j = 0; j < 16; j++) begin
            for (int i = 0; i < 16; i++) begin
                logic [31:0] xe = op[29] ? 32'd0 : xv[i*32 +: 32];
                logic [31:0] ye = op[28] ? 32'd0 : yv[j*32 +: 32];
                logic [31:0] p  = xe * ye;
                logic [31:0] o  = model[t + 4*j][i*32 +: 32];
                logic [31:0] n;
                if (op[27]) n = sub ? (32'd0 - p) : p;
                else        n = sub ? (o - p) : (o + p);
                model[t + 4*j][i*32 +: 32] = n;
            end
        end
    endtask

    // Issue one command; optionally offer an intruder command while busy.
    task automatic run_cmd(string tag, logic [63:0] op, logic sub,
                           logic [511:0] xv, logic [511:0] yv, bit intrude);
        int n;
        cmd_valid = 1'b1; cmd_op = op; cmd_sub = sub; x_vec = xv; y_vec = yv;
        @(posedge clk); @(negedge clk);
        model_apply(op, sub, xv, yv);
        cmd_valid = 1'b0;
        if (intrude) begin
            cmd_valid = 1'b1;
            cmd_op = {op[63:22], ~op[21:20], 20'h0};
            cmd_sub = ~sub;
            x_vec = make_vec(777); y_vec = make_vec(778);
        end
        n = 0;
        while (busy && n < 40) begin
            // R2: ready must be low while busy
            check1({tag, " R2 ready low"}, {511'd0, cmd_ready}, 512'd0);
            n++;
            @(negedge clk);
        end
        cmd_valid = 1'b0;
        // R3: busy lasted exactly 16 cycles
        check1({tag, " R3 busy length"}, 512'(n), 512'd16);
        if (intrude) begin
            @(negedge clk);
            // R2: held-off command was not taken
            check1({tag, " R2 no late accept"}, {511'd0, busy}, 512'd0);
        end
        check_all(tag);
    endtask

    initial begin
        rst = 1'b1; cmd_valid = 1'b0; cmd_op = '0; cmd_sub = 1'b0;
        x_vec = '0; y_vec = '0; rd_idx = '0;
        for (int r = 0; r < 64; r++) model[r] = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1: reset state visible during reset
        check1("R1 busy in reset", {511'd0, busy}, 512'd0);
        rst = 1'b0;
        @(negedge clk);
        check1("R1 ready after reset", {511'd0, cmd_ready}, 512'd1);
        check_all("R1 zero rows R9");

        // Sweep tiles x flags x subtract (R4..R8, R9)
        for (int t = 0; t < 4; t++) begin
            for (int f = 0; f < 16; f++) begin
                logic [63:0] op = 64'h0;
                string tg;
                op[21:20] = 2'(t);
                op[27] = f[0]; op[28] = f[1]; op[29] = f[2];
                tg = $sformatf("R4 R5 R6 R7 R8 t%0d f%0d", t, f);
                run_cmd(tg, op, f[3], make_vec(t*16+f), make_vec(t*16+f+100), 1'b0);
            end
        end

        // R8: unrelated operand bits ignored
        run_cmd("R8 other bits", 64'hC3F0_FFFF_07C0_FFFF & ~64'h0000_0000_3830_0000 | 64'h0000_0000_0020_0000,
                1'b0, make_vec(5), make_vec(6), 1'b0);

        // R2: commands offered while busy are held off
        run_cmd("R2 holdoff", 64'h0000_0000_0010_0000, 1'b0, make_vec(9), make_vec(10), 1'b1);
        run_cmd("R2 holdoff sub", 64'h0000_0000_0030_0000, 1'b1, make_vec(11), make_vec(12), 1'b1);

        // R10: wrap modulo 2^32
        begin
            logic [511:0] big = '0;
            for (int i = 0; i < 16; i++) big[i*32 +: 32] = 32'h7FFF_FFFF;
            run_cmd("R10 wrap ovr", 64'h0000_0000_0800_0000, 1'b0, big, big, 1'b0);
            run_cmd("R10 wrap acc", 64'h0000_0000_0000_0000, 1'b0, big, big, 1'b0);
            run_cmd("R10 wrap acc2", 64'h0000_0000_0000_0000, 1'b0, big, big, 1'b0);
        end

        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end
endmodule